// File: doc/BRIEF.md
# Vector Lane Narrow, Widen and Reduce Unit

This unit reshapes the lanes of a 128-bit vector. It can pack two vectors of wide lanes into one vector of lanes half as wide, clamping each value into the narrower range. It can widen half of a vector's lanes to twice their width using sign or zero fill. It can also collapse a vector into a scalar: a mask of lane sign bits, a flag that is set when any bit is set, or a flag that is set when every lane is non-zero.

An operation is presented with `in_valid_i`, an opcode, a source lane size code and two operand vectors. The result appears one clock later on a vector output and a 32-bit scalar output, and it is held until the next valid operation. Vector operations drive the scalar output to zero. Reductions drive the vector output to zero. Opcodes that are not defined, and lane sizes that an opcode does not support, give zero on both outputs.

Opcode encoding (`op_i`): 0 signed narrow, 1 unsigned narrow, 2 widen low signed, 3 widen low unsigned, 4 widen high signed, 5 widen high unsigned, 6 sign mask, 7 any-set, 8 all-lanes-set, 9 to 15 undefined. Size encoding (`size_i`, the source lane width): 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64. Lane k of a vector with lane width W occupies bits [k*W+W-1 : k*W].

Top module: `lnx_unit`

## Requirements
- R1: Narrowing (op 0 or 1, size 1 or 2, output lane width D = half the source width, N = 128/source width) writes the clamped source lane i of `vec_a_i` to output lane i and source lane i of `vec_b_i` to output lane N+i.
- R2: Signed narrowing (op 0) reads each source lane as signed and clamps it to the range -2^(D-1) to 2^(D-1)-1; for 16-to-8 that is 0x80 to 0x7F.
- R3: Unsigned narrowing (op 1) also reads each source lane as signed; a negative lane becomes 0, a lane above 2^D-1 becomes all ones (0xFF for 16-to-8), and a lane in range passes through.
- R4: Widening (ops 2 to 5, size 0, 1 or 2) gives N = 64/source width output lanes of twice the source width; the low forms (2, 3) take source lanes 0 to N-1, the high forms (4, 5) take lanes N to 2N-1; ops 2 and 4 fill the upper half with the lane's top bit, ops 3 and 5 fill it with zeros.
- R5: The sign mask (op 6) sets scalar bit i to the most significant bit of lane i for every lane of the selected size (8, 16, 32 or 64 bits); all higher scalar bits are zero.
- R6: All-lanes-set (op 8) gives scalar 1 only when every lane of the selected size is non-zero, else 0.
- R7: Any-set (op 7) gives scalar 1 when any bit of `vec_a_i` is 1, for every size code, else 0.
- R8: Vector operations give scalar 0; reductions give vector 0; ops 9 to 15, narrowing with size 0 or 3, and widening with size 3 give zero on both outputs.
- R9: Results appear the clock after `in_valid_i` is high with `out_valid_o` high; while `in_valid_i` is low, `out_valid_o` falls and both outputs hold; reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 4 | Opcode |
| size_i | input | 2 | Source lane width code |
| vec_a_i | input | 128 | First operand vector |
| vec_b_i | input | 128 | Second operand vector (narrowing only) |
| out_valid_o | output | 1 | Result registered from the previous cycle |
| vec_o | output | 128 | Vector result |
| scalar_o | output | 32 | Scalar result |

## Verification
The bench aims at the clamp edges: lanes one past the signed maximum and one below the signed minimum, values that fit the unsigned range only, and negative lanes in unsigned narrowing, where a design that treated the source as unsigned would return all ones instead of zero. It checks the half-select of widening and the operand order of narrowing, where a swap would mirror lanes between halves. Sign masks at 64-bit lanes catch high scalar bits left set, and an all-lanes test with a single zero byte, which still passes at 64-bit lanes, catches a design that checks the wrong lane width. Unsupported size codes and undefined opcodes must give zeros rather than a neighbouring mode's result.

// File: rtl/lnx_pkg.sv
package lnx_pkg;

  // Operation codes presented on op_i.
  typedef enum logic [3:0] {
    OP_NAR_S   = 4'd0,
    OP_NAR_U   = 4'd1,
    OP_WLO_S   = 4'd2,
    OP_WLO_U   = 4'd3,
    OP_WHI_S   = 4'd4,
    OP_WHI_U   = 4'd5,
    OP_SGNMASK = 4'd6,
    OP_ANYSET  = 4'd7,
    OP_ALLSET  = 4'd8
  } lnx_op_e;

  // Number of lane size codes (8 << code bits).
  localparam int LNX_NSZ     = 4;
  // Size codes that narrowing accepts (source width).
  localparam int LNX_NAR_LO  = 1;
  localparam int LNX_NAR_HI  = 2;
  // Largest size code that widening accepts (source width).
  localparam int LNX_WID_HI  = 2;

  function automatic logic is_narrow(lnx_op_e op);
    return (op == OP_NAR_S) || (op == OP_NAR_U);
  endfunction

  function automatic logic is_widen(lnx_op_e op);
    return (op == OP_WLO_S) || (op == OP_WLO_U) ||
           (op == OP_WHI_S) || (op == OP_WHI_U);
  endfunction

endpackage

// File: rtl/lnx_narrow.sv
// Packs two vectors of SRC_W-bit lanes into one vector of SRC_W/2-bit
// lanes with saturation; sources are always read as signed.
module lnx_narrow #(
  parameter int VEC_W = 128,
  parameter int SRC_W = 16
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             uns_i,
  output logic [VEC_W-1:0] y_o
);
  localparam int N = VEC_W / SRC_W;
  localparam int D = SRC_W / 2;

  for (genvar i = 0; i < 2 * N; i++) begin : g_lane
    logic [SRC_W-1:0] src;
    logic [D-1:0]     sat;
    logic             fits_s;
    logic             fits_u;
    logic             neg;

    if (i < N) begin : g_from_a
      assign src = a_i[i*SRC_W +: SRC_W];
    end else begin : g_from_b
      assign src = b_i[(i-N)*SRC_W +: SRC_W];
    end

    assign neg    = src[SRC_W-1];
    // Signed fit: bits above the new sign bit all copy the sign.
    assign fits_s = (src[SRC_W-1:D-1] == {(D+1){neg}});
    // Unsigned fit: no bits set above the narrow width.
    assign fits_u = (src[SRC_W-1:D] == '0);

    always_comb begin
      if (uns_i) begin
        if (fits_u)   sat = src[D-1:0];
        else if (neg) sat = '0;
        else          sat = '1;
      end else begin
        if (fits_s)   sat = src[D-1:0];
        else if (neg) sat = {1'b1, {(D-1){1'b0}}};
        else          sat = {1'b0, {(D-1){1'b1}}};
      end
    end

    assign y_o[i*D +: D] = sat;
  end

endmodule

// File: rtl/lnx_widen.sv
// Widens the low or high half of the SRC_W-bit lanes to 2*SRC_W bits.
module lnx_widen #(
  parameter int VEC_W = 128,
  parameter int SRC_W = 8
) (
  input  logic [VEC_W-1:0] v_i,
  input  logic             hi_i,
  input  logic             uns_i,
  output logic [VEC_W-1:0] y_o
);
  localparam int DST_W = 2 * SRC_W;
  localparam int N     = VEC_W / DST_W;

  for (genvar i = 0; i < N; i++) begin : g_lane
    logic [SRC_W-1:0] lo_src;
    logic [SRC_W-1:0] hi_src;
    logic [SRC_W-1:0] src;
    logic             fill;

    assign lo_src = v_i[i*SRC_W +: SRC_W];
    assign hi_src = v_i[(i+N)*SRC_W +: SRC_W];
    assign src    = hi_i ? hi_src : lo_src;
    assign fill   = ~uns_i & src[SRC_W-1];
    assign y_o[i*DST_W +: DST_W] = {{SRC_W{fill}}, src};
  end

endmodule

// File: rtl/lnx_reduce.sv
// Collapses a vector into a sign mask and two flags for each lane size.
module lnx_reduce #(
  parameter int VEC_W = 128,
  parameter int SC_W  = 32,
  parameter int NSZ   = 4
) (
  input  logic [VEC_W-1:0]       v_i,
  input  logic [$clog2(NSZ)-1:0] sz_i,
  output logic [SC_W-1:0]        mask_o,
  output logic                   all_o,
  output logic                   any_o
);
  logic [SC_W-1:0] mask_g [NSZ];
  logic            all_g  [NSZ];

  for (genvar g = 0; g < NSZ; g++) begin : g_sz
    localparam int LW = 8 << g;
    localparam int N  = VEC_W / LW;
    logic [N-1:0] msb;
    logic [N-1:0] nz;

    for (genvar i = 0; i < N; i++) begin : g_lane
      assign msb[i] = v_i[i*LW + LW - 1];
      assign nz[i]  = |v_i[i*LW +: LW];
    end

    assign mask_g[g] = SC_W'(msb);
    assign all_g[g]  = &nz;
  end

  assign mask_o = mask_g[sz_i];
  assign all_o  = all_g[sz_i];
  assign any_o  = |v_i;

endmodule

// File: rtl/lnx_unit.sv
// Lane narrow, widen and reduce unit with a registered result.
module lnx_unit
  import lnx_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int SC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic [3:0]       op_i,
  input  logic [1:0]       size_i,
  input  logic [VEC_W-1:0] vec_a_i,
  input  logic [VEC_W-1:0] vec_b_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [SC_W-1:0]  scalar_o
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Operation decode.
  lnx_op_e op_e;
  logic    nar_uns;
  logic    wid_uns;
  logic    wid_hi;

  assign op_e    = lnx_op_e'(op_i);
  assign nar_uns = (op_e == OP_NAR_U);
  assign wid_uns = (op_e == OP_WLO_U) || (op_e == OP_WHI_U);
  assign wid_hi  = (op_e == OP_WHI_S) || (op_e == OP_WHI_U);

  // One datapath variant per size code; unsupported codes yield zero.
  logic [VEC_W-1:0] nar_y [LNX_NSZ];
  logic [VEC_W-1:0] wid_y [LNX_NSZ];

  for (genvar g = 0; g < LNX_NSZ; g++) begin : g_sz
    localparam int LW = 8 << g;

    if (g >= LNX_NAR_LO && g <= LNX_NAR_HI) begin : g_nar
      lnx_narrow #(.VEC_W(VEC_W), .SRC_W(LW)) i_narrow (
        .a_i   (vec_a_i),
        .b_i   (vec_b_i),
        .uns_i (nar_uns),
        .y_o   (nar_y[g])
      );
    end else begin : g_nar_none
      assign nar_y[g] = '0;
    end

    if (g <= LNX_WID_HI) begin : g_wid
      lnx_widen #(.VEC_W(VEC_W), .SRC_W(LW)) i_widen (
        .v_i   (vec_a_i),
        .hi_i  (wid_hi),
        .uns_i (wid_uns),
        .y_o   (wid_y[g])
      );
    end else begin : g_wid_none
      assign wid_y[g] = '0;
    end
  end

  logic [SC_W-1:0] red_mask;
  logic            red_all;
  logic            red_any;

  lnx_reduce #(.VEC_W(VEC_W), .SC_W(SC_W), .NSZ(LNX_NSZ)) i_reduce (
    .v_i    (vec_a_i),
    .sz_i   (size_i),
    .mask_o (red_mask),
    .all_o  (red_all),
    .any_o  (red_any)
  );

  // Result select.
  logic [VEC_W-1:0] vec_d;
  logic [SC_W-1:0]  sc_d;

  always_comb begin
    vec_d = '0;
    sc_d  = '0;
    if (is_narrow(op_e)) begin
      vec_d = nar_y[size_i];
    end else if (is_widen(op_e)) begin
      vec_d = wid_y[size_i];
    end else begin
      case (op_e)
        OP_SGNMASK: sc_d = red_mask;
        OP_ANYSET:  sc_d = SC_W'(red_any);
        OP_ALLSET:  sc_d = SC_W'(red_all);
        default:    sc_d = '0;
      endcase
    end
  end

  // Next state with explicit clock enable.
  logic             valid_q, valid_n;
  logic [VEC_W-1:0] vec_q,   vec_n;
  logic [SC_W-1:0]  sc_q,    sc_n;

  always_comb begin
    valid_n = in_valid_i;
    vec_n   = vec_q;
    sc_n    = sc_q;
    if (in_valid_i) begin
      vec_n = vec_d;
      sc_n  = sc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      sc_q    <= '0;
    end else begin
      valid_q <= valid_n;
      vec_q   <= vec_n;
      sc_q    <= sc_n;
    end
  end

  assign out_valid_o = valid_q;
  assign vec_o       = vec_q;
  assign scalar_o    = sc_q;

endmodule

// File: rtl/lnx_unit_chk.sv
module lnx_unit_chk #(
  parameter int VEC_W = 128,
  parameter int SC_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid_i,
  input logic [3:0]       op_i,
  input logic [1:0]       size_i,
  input logic [VEC_W-1:0] vec_a_i,
  input logic             out_valid_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [SC_W-1:0]  scalar_o
);

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> (!out_valid_o && $stable(vec_o) && $stable(scalar_o)));

  assert_sat_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i == 4'd0 && size_i == 2'd1 &&
     !vec_a_i[15] && vec_a_i[14:7] != '0) |=> vec_o[7:0] == 8'h7F);

  assert_neg_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i == 4'd1 && size_i == 2'd1 && vec_a_i[15])
    |=> vec_o[7:0] == 8'h00);

  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i == 4'd3 && size_i == 2'd0) |=> vec_o[15:8] == 8'h00);

  assert_mask_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i == 4'd6 && size_i >= 2'd2) |=> scalar_o[SC_W-1:4] == '0);

  assert_all_zero_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i == 4'd8 && vec_a_i == '0) |=> scalar_o == '0);

  assert_any_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i == 4'd7) |=> scalar_o == SC_W'($past(vec_a_i) != '0));

  assert_vec_op_scalar_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i <= 4'd5) |=> scalar_o == '0);

  assert_reduce_vec_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && op_i >= 4'd6) |=> vec_o == '0);

endmodule

bind lnx_unit lnx_unit_chk #(.VEC_W(VEC_W), .SC_W(SC_W)) i_lnx_unit_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .in_valid_i  (in_valid_i),
  .op_i        (op_i),
  .size_i      (size_i),
  .vec_a_i     (vec_a_i),
  .out_valid_o (out_valid_o),
  .vec_o       (vec_o),
  .scalar_o    (scalar_o)
);

// File: tb/test_lnx_unit.sv
module test_lnx_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NT         = 18;
  localparam int NRAND      = 400;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [3:0]   op;
  logic [1:0]   sz;
  logic [127:0] va, vb;
  logic         out_valid;
  logic [127:0] vec_out;
  logic [31:0]  sc_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lnx_unit i_lnx_unit (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .op_i(op), .size_i(sz),
    .vec_a_i(va), .vec_b_i(vb), .out_valid_o(out_valid), .vec_o(vec_out),
    .scalar_o(sc_out)
  );

  // Stimulus and expected results, written from the requirements.
  localparam logic [3:0] T_OP [NT] = '{4'd0, 4'd1, 4'd0, 4'd1, 4'd2, 4'd5, 4'd4, 4'd3,
                                       4'd6, 4'd6, 4'd8, 4'd8, 4'd7, 4'd7, 4'd0, 4'd2,
                                       4'd9, 4'd6};
  localparam logic [1:0] T_SZ [NT] = '{2'd1, 2'd1, 2'd2, 2'd2, 2'd0, 2'd0, 2'd2, 2'd1,
                                       2'd0, 2'd2, 2'd3, 2'd0, 2'd0, 2'd3, 2'd0, 2'd3,
                                       2'd0, 2'd3};
  localparam logic [127:0] T_A [NT] = '{
    128'h80007FFFFF7FFF800080007FFFFB0005,
    128'h80007FFFFF7FFF800080007FFFFB0005,
    128'hFFFF7FFFFFFF80000000800000007FFF,
    128'hFFFF7FFFFFFF80000000800000007FFF,
    128'h8F0E8D0C8B0A8908F7F6F5F4F3F2F1F0,
    128'h8F0E8D0C8B0A8908F7F6F5F4F3F2F1F0,
    128'h800000017FFFFFFF0000000000000000,
    128'h8F0E8D0C8B0A8908F7F6F5F4F3F2F1F0,
    128'h8F0E8D0C8B0A8908F7F6F5F4F3F2F1F0,
    128'h00FF0000800000007FFFFFFFFFFFFFFF,
    128'h00000000000000018000000000000000,
    128'h01010101010101010101010101010100,
    128'h80000000000000000000000000000000,
    128'h00000000000000000000000000000000,
    128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF,
    128'h8F0E8D0C8B0A8908F7F6F5F4F3F2F1F0,
    128'h8F0E8D0C8B0A8908F7F6F5F4F3F2F1F0,
    128'h00000000000000018000000000000000};
  localparam logic [127:0] T_B [NT] = '{
    128'h0,
    128'h00FF00FF00FF00FF00FF00FF00FF00FF,
    128'hFFFFFFFF000000018000000012345678,
    128'hFFFFFFFF000000018000000012345678,
    128'h0, 128'h0, 128'h0, 128'h0, 128'h0, 128'h0, 128'h0, 128'h0, 128'h0, 128'h0,
    128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF,
    128'h0, 128'h0, 128'h0};
  localparam logic [127:0] T_EV [NT] = '{
    128'h0000000000000000807F80807F7FFB05,
    128'hFFFFFFFFFFFFFFFF00FF0000807F0005,
    128'hFFFF000180007FFF800080007FFF7FFF,
    128'h000000010000FFFF0000000080007FFF,
    128'hFFF7FFF6FFF5FFF4FFF3FFF2FFF1FFF0,
    128'h008F000E008D000C008B000A00890008,
    128'hFFFFFFFF80000001000000007FFFFFFF,
    128'h0000F7F60000F5F40000F3F20000F1F0,
    128'h0, 128'h0, 128'h0, 128'h0, 128'h0, 128'h0, 128'h0, 128'h0, 128'h0, 128'h0};
  localparam logic [31:0] T_ES [NT] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0000AAFF, 32'h5, 32'h1, 32'h0, 32'h1, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1};
  // Requirement number each entry targets (R1..R8).
  localparam int T_REQ [NT] = '{2, 3, 1, 3, 4, 4, 4, 4, 5, 5, 6, 6, 7, 7, 8, 8, 8, 5};

  // ---------------- reference model ----------------
  function automatic logic [127:0] lane_of(logic [127:0] v, int w, int i);
    return (v >> (i * w)) & ~(~128'd0 << w);
  endfunction

  function automatic logic [127:0] ref_vec(logic [3:0] o, logic [1:0] s,
                                           logic [127:0] a, logic [127:0] b);
    logic [127:0] r;
    int w;
    r = '0;
    w = 8 << s;
    if (o <= 4'd1 && (s == 2'd1 || s == 2'd2)) begin
      int d;
      int n;
      longint hi;
      longint lo;
      d  = w / 2;
      n  = 128 / w;
      hi = (o == 4'd0) ? (64'sd1 <<< (d - 1)) - 1 : (64'sd1 <<< d) - 1;
      lo = (o == 4'd0) ? -(64'sd1 <<< (d - 1)) : 64'sd0;
      for (int i = 0; i < 2 * n; i++) begin
        logic [127:0] src;
        longint sv;
        src = (i < n) ? lane_of(a, w, i) : lane_of(b, w, i - n);
        sv  = longint'(src[63:0]);
        if (src[w-1]) sv = sv - (64'sd1 <<< w);
        if (sv > hi) sv = hi;
        if (sv < lo) sv = lo;
        r = r | ((128'(sv) & ~(~128'd0 << d)) << (i * d));
      end
    end else if (o >= 4'd2 && o <= 4'd5 && s <= 2'd2) begin
      int n;
      int base;
      n    = 128 / (2 * w);
      base = (o >= 4'd4) ? n : 0;
      for (int i = 0; i < n; i++) begin
        logic [127:0] src;
        src = lane_of(a, w, base + i);
        if ((o == 4'd2 || o == 4'd4) && src[w-1]) src = src | (~128'd0 << w);
        src = src & ~(~128'd0 << (2 * w));
        r = r | (src << (i * 2 * w));
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_sc(logic [3:0] o, logic [1:0] s, logic [127:0] a);
    logic [31:0] r;
    int w;
    r = '0;
    w = 8 << s;
    if (o == 4'd6) begin
      for (int i = 0; i < 128 / w; i++) r[i] = a[i*w + w - 1];
    end else if (o == 4'd7) begin
      r = (a != '0) ? 32'd1 : 32'd0;
    end else if (o == 4'd8) begin
      r = 32'd1;
      for (int i = 0; i < 128 / w; i++) if (lane_of(a, w, i) == '0) r = 32'd0;
    end
    return r;
  endfunction

  function automatic int req_of(logic [3:0] o, logic [1:0] s);
    if (o <= 4'd1) return (s == 2'd1 || s == 2'd2) ? ((o == 4'd0) ? 2 : 3) : 8;
    if (o <= 4'd5) return (s <= 2'd2) ? 4 : 8;
    if (o == 4'd6) return 5;
    if (o == 4'd7) return 7;
    if (o == 4'd8) return 6;
    return 8;
  endfunction

  // Vector of lanes of width 8<<s, each zero, all ones, a sign boundary or random.
  function automatic logic [127:0] mk_vec(logic [1:0] s);
    logic [127:0] v;
    int w;
    v = '0;
    w = 8 << s;
    for (int i = 0; i < 128 / w; i++) begin
      logic [127:0] ln;
      case ($urandom_range(0, 5))
        0:       ln = '0;
        1:       ln = ~128'd0;
        2:       ln = 128'd1 << (w - 1);
        3:       ln = (128'd1 << (w - 1)) - 1;
        default: ln = {$urandom, $urandom, $urandom, $urandom};
      endcase
      ln = ln & ~(~128'd0 << w);
      v  = v | (ln << (i * w));
    end
    return v;
  endfunction

  // ---------------- checking ----------------
  task automatic check_out(int req, string what, logic ev_valid,
                           logic [127:0] ev, logic [31:0] es);
    checks++;
    if (out_valid !== ev_valid || vec_out !== ev || sc_out !== es) begin
      errors++;
      $display("FAIL R%0d %s: actual valid=%0b vec=%h sc=%h expected valid=%0b vec=%h sc=%h",
               req, what, out_valid, vec_out, sc_out, ev_valid, ev, es);
    end
  endtask

  task automatic apply(logic [3:0] o, logic [1:0] s, logic [127:0] a, logic [127:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    op = o; sz = s; va = a; vb = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; sz = '0; va = '0; vb = '0;
    repeat (3) @(negedge clk);
    check_out(9, "state during reset", 1'b0, '0, '0);            // R9
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out(9, "state after reset release", 1'b0, '0, '0);     // R9

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int t = 0; t < NT; t++) begin
      apply(T_OP[t], T_SZ[t], T_A[t], T_B[t]);
      check_out(T_REQ[t], $sformatf("table entry %0d", t), 1'b1, T_EV[t], T_ES[t]);
    end

    // R9: idle cycles hold the result while inputs change.
    apply(4'd2, 2'd0, T_A[4], '0);
    op = 4'd6; sz = 2'd3; va = ~128'd0; vb = ~128'd0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_out(9, "hold while idle", 1'b0, T_EV[4], '0);
    end

    // R9: back-to-back operations each land one cycle later.
    @(negedge clk);
    in_valid = 1'b1; op = 4'd7; sz = 2'd0; va = 128'd1; vb = '0;
    @(negedge clk);
    check_out(7, "back-to-back first", 1'b1, '0, 32'd1);
    op = 4'd8; sz = 2'd3; va = 128'h1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(6, "back-to-back second", 1'b1, '0, 32'd0);

    // Random sweep over every opcode and size code against the model.
    for (int n = 0; n < NRAND; n++) begin
      logic [3:0]   o;
      logic [1:0]   s;
      logic [127:0] a;
      logic [127:0] b;
      o = 4'($urandom_range(0, 10));
      s = 2'($urandom_range(0, 3));
      a = mk_vec(s);
      b = mk_vec(s);
      apply(o, s, a, b);
      check_out(req_of(o, s), $sformatf("random op=%0d size=%0d", o, s),
                1'b1, ref_vec(o, s, a, b), ref_sc(o, s, a));
    end

    // R9: reset in mid-run clears the registered result.
    apply(4'd0, 2'd1, T_A[0], T_B[0]);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_out(9, "asynchronous reset clears", 1'b0, '0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out(9, "after second reset", 1'b0, '0, '0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule